// File: doc/BRIEF.md
# H-Bridge Command Decode and Fault Latch

This block is the digital control core of a driver with two half-bridge legs. It turns per-leg polarity commands, an active-high disable and an active-high enable (low means sleep) into per-leg high-side and low-side gate enables, an active-low status flag and a sleep indication. Any input can be marked as floating, and a floating input then takes a fixed default value.

A short-circuit or over-temperature report latches the bridge off, and the status flag stays low until a qualifying edge arrives on a disable-type input or a power-on reset occurs. An over-temperature latch also waits for a temperature-ok indication before it can clear. Under-voltage turns the bridge off and pulls the flag low, and it recovers on its own.

The mode register holds one of five states: SLEEP, OFF (disabled), UVLO, DRIVE and TRIPPED. The named transitions are:
- doze: any untripped state goes to SLEEP when enable is low.
- trip: an untripped state goes to TRIPPED when enable is high and a short or over-temperature is reported.
- settle: an untripped state goes to UVLO, OFF or DRIVE according to the inputs.
- release: TRIPPED goes to the settled state when a clear edge arrives and the release is permitted.
- hold: TRIPPED stays in TRIPPED in every other case.

Top module: `hbridge_ctrl`

## Requirements
- R1: While reset is asserted, and on leaving reset, the mode is SLEEP. All gate enables are 0, `stat_n` is 1 and `sleep_o` is 1. The first clock edge after reset selects the mode from the inputs.
- R2: In DRIVE (enable 1, disable 0, no fault), leg i has `hs_en[i]` equal to polarity bit i and `ls_en[i]` equal to its inverse. A polarity change shows at the outputs with no clock delay. `stat_n` is 1 and `sleep_o` is 0.
- R3: Disable at 1 with enable at 1 turns off every gate enable and drives `stat_n` to 0 from the next clock edge.
- R4: Enable at 0 enters SLEEP at the next edge unless the bridge is TRIPPED. All gates are off, `stat_n` is 1 and `sleep_o` is 1. Fault reports are ignored while asleep.
- R5: Under-voltage turns the gates off and drives `stat_n` to 0. Once it goes away, the mode given by the other inputs returns at the next edge, with no clear edge needed.
- R6: A short-circuit or over-temperature report while enable is 1 enters TRIPPED at the next edge. All gates are off and `stat_n` is 0. This persists whatever the levels of polarity, disable, enable and the fault lines.
- R7: TRIPPED is left at the edge that samples either a 1-to-0 change of the effective disable or a 0-to-1 change of the effective enable. The new mode is the one the current inputs select.
- R8: A latch caused by over-temperature is released by a clear edge only while `temp_ok` is 1. Otherwise it holds.
- R9: A fault still present at release gives one cycle of the settled mode, and the bridge trips again at the following edge.
- R10: Floating defaults: a floating polarity reads as 1, a floating disable reads as 1 and a floating enable reads as 0. Edges on the effective values count as clear edges.
- R11: The two enables of one leg are never 1 together. Every mode other than DRIVE clears both.
- R12: Priority: an existing latch overrides everything, then sleep, then a new fault, then under-voltage, then disable. A fault reported during UVLO latches.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous power-on reset |
| pol_in | input | NUM_LEGS | Polarity command per leg, 1 selects the supply |
| pol_float | input | NUM_LEGS | Per-leg flag marking the polarity input as undriven |
| dis_in | input | 1 | Disable command, active high |
| dis_float | input | 1 | Marks the disable input as undriven |
| wake_in | input | 1 | Enable command, 0 selects sleep |
| wake_float | input | 1 | Marks the enable input as undriven |
| uv_flt | input | 1 | Under-voltage report |
| short_flt | input | 1 | Short-circuit report |
| hot_flt | input | 1 | Over-temperature report |
| temp_ok | input | 1 | Temperature back below the trip point minus hysteresis |
| hs_en | output | NUM_LEGS | High-side gate enable per leg |
| ls_en | output | NUM_LEGS | Low-side gate enable per leg |
| stat_n | output | 1 | Status flag, active low |
| sleep_o | output | 1 | High in SLEEP |

## Verification
The hardest situation to reach is the one-cycle release window of R9. In that window the settled mode is visible while a still-present short re-trips the bridge at the next edge. The stimulus holds the short line high through a full disable pulse and samples the outputs both after the release edge and after the edge that follows it. A second awkward case is an over-temperature latch meeting a clear edge while `temp_ok` is low. The bench builds this by dropping `temp_ok` before pulsing disable, then repeats the pulse after raising `temp_ok`.

// File: rtl/hb_pkg.sv
package hb_pkg;
    typedef enum logic [2:0] {
        HB_SLEEP   = 3'd0,
        HB_OFF     = 3'd1,
        HB_UVLO    = 3'd2,
        HB_DRIVE   = 3'd3,
        HB_TRIPPED = 3'd4
    } hb_mode_e;
endpackage

// File: rtl/hb_input_resolve.sv
module hb_input_resolve #(
    parameter int NUM_LEGS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] pol_raw,
    input  logic [NUM_LEGS-1:0] pol_float,
    input  logic                dis_raw,
    input  logic                dis_float,
    input  logic                wake_raw,
    input  logic                wake_float,
    output logic [NUM_LEGS-1:0] pol_eff,
    output logic                dis_eff,
    output logic                wake_eff,
    output logic                clr_edge
);
    logic dis_q;
    logic wake_q;

    // Floating polarity inputs read as 1 (R10).
    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_pol
        assign pol_eff[g] = pol_float[g] ? 1'b1 : pol_raw[g];
    end

    assign dis_eff  = dis_float  ? 1'b1 : dis_raw;
    assign wake_eff = wake_float ? 1'b0 : wake_raw;

    // Previous effective levels, reset to the floating defaults.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dis_q  <= 1'b1;
            wake_q <= 1'b0;
        end else begin
            dis_q  <= dis_eff;
            wake_q <= wake_eff;
        end
    end

    // Clear edge: disable falling or enable rising (R7).
    assign clr_edge = (dis_q & ~dis_eff) | (~wake_q & wake_eff);
endmodule

// File: rtl/hb_mode_fsm.sv
module hb_mode_fsm
    import hb_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dis_eff,
    input  logic     wake_eff,
    input  logic     clr_edge,
    input  logic     uv_flt,
    input  logic     short_flt,
    input  logic     hot_flt,
    input  logic     temp_ok,
    output hb_mode_e mode
);
    hb_mode_e mode_q, mode_d, settled;
    logic     hot_cause_q, hot_cause_d;
    logic     fault_hit;
    logic     release_ok;

    // Mode chosen when no latch is involved (R12 ordering).
    always_comb begin
        if (!wake_eff)     settled = HB_SLEEP;
        else if (uv_flt)   settled = HB_UVLO;
        else if (dis_eff)  settled = HB_OFF;
        else               settled = HB_DRIVE;
    end

    assign fault_hit  = wake_eff & (short_flt | hot_flt);
    assign release_ok = clr_edge & (~hot_cause_q | temp_ok);

    always_comb begin
        mode_d      = mode_q;
        hot_cause_d = hot_cause_q;
        unique case (mode_q)
            HB_TRIPPED: begin
                if (release_ok) begin
                    mode_d      = settled;
                    hot_cause_d = 1'b0;
                end
            end
            HB_SLEEP, HB_OFF, HB_UVLO, HB_DRIVE: begin
                if (fault_hit) begin
                    mode_d      = HB_TRIPPED;
                    hot_cause_d = hot_flt;
                end else begin
                    mode_d      = settled;
                end
            end
            default: begin
                mode_d      = HB_SLEEP;
                hot_cause_d = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q      <= HB_SLEEP;
            hot_cause_q <= 1'b0;
        end else begin
            mode_q      <= mode_d;
            hot_cause_q <= hot_cause_d;
        end
    end

    assign mode = mode_q;

    // R6
    trip_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HB_TRIPPED && !clr_edge) |=> (mode_q == HB_TRIPPED));

    // R8
    hot_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HB_TRIPPED && hot_cause_q && !temp_ok) |=> (mode_q == HB_TRIPPED));

    // R4
    sleep_entry_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != HB_TRIPPED && !wake_eff) |=> (mode_q == HB_SLEEP));

    // R9
    relatch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q != HB_TRIPPED && wake_eff && short_flt) |=> (mode_q == HB_TRIPPED));

    // R5
    uv_recover_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == HB_UVLO && wake_eff && !uv_flt && !short_flt && !hot_flt && !dis_eff)
        |=> (mode_q == HB_DRIVE));
endmodule

// File: rtl/hb_leg_drive.sv
module hb_leg_drive (
    input  logic clk,
    input  logic rst_n,
    input  logic drive_on,
    input  logic pol,
    output logic hs,
    output logic ls
);
    assign hs = drive_on &  pol;
    assign ls = drive_on & ~pol;

    // R11
    leg_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(hs && ls));
endmodule

// File: rtl/hbridge_ctrl.sv
module hbridge_ctrl
    import hb_pkg::*;
#(
    parameter int NUM_LEGS = 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_LEGS-1:0] pol_in,
    input  logic [NUM_LEGS-1:0] pol_float,
    input  logic                dis_in,
    input  logic                dis_float,
    input  logic                wake_in,
    input  logic                wake_float,
    input  logic                uv_flt,
    input  logic                short_flt,
    input  logic                hot_flt,
    input  logic                temp_ok,
    output logic [NUM_LEGS-1:0] hs_en,
    output logic [NUM_LEGS-1:0] ls_en,
    output logic                stat_n,
    output logic                sleep_o
);
    logic [NUM_LEGS-1:0] pol_eff;
    logic                dis_eff;
    logic                wake_eff;
    logic                clr_edge;
    logic                drive_on;
    hb_mode_e            mode;

    hb_input_resolve #(.NUM_LEGS(NUM_LEGS)) u_inputs (
        .clk       (clk),
        .rst_n     (rst_n),
        .pol_raw   (pol_in),
        .pol_float (pol_float),
        .dis_raw   (dis_in),
        .dis_float (dis_float),
        .wake_raw  (wake_in),
        .wake_float(wake_float),
        .pol_eff   (pol_eff),
        .dis_eff   (dis_eff),
        .wake_eff  (wake_eff),
        .clr_edge  (clr_edge)
    );

    hb_mode_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .dis_eff  (dis_eff),
        .wake_eff (wake_eff),
        .clr_edge (clr_edge),
        .uv_flt   (uv_flt),
        .short_flt(short_flt),
        .hot_flt  (hot_flt),
        .temp_ok  (temp_ok),
        .mode     (mode)
    );

    always_comb begin
        drive_on = 1'b0;
        stat_n   = 1'b1;
        sleep_o  = 1'b0;
        unique case (mode)
            HB_SLEEP:   sleep_o  = 1'b1;
            HB_OFF:     stat_n   = 1'b0;
            HB_UVLO:    stat_n   = 1'b0;
            HB_DRIVE:   drive_on = 1'b1;
            HB_TRIPPED: stat_n   = 1'b0;
            default:    sleep_o  = 1'b1;
        endcase
    end

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        hb_leg_drive u_leg (
            .clk     (clk),
            .rst_n   (rst_n),
            .drive_on(drive_on),
            .pol     (pol_eff[g]),
            .hs      (hs_en[g]),
            .ls      (ls_en[g])
        );
    end

    // R3
    dis_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(dis_eff) && $past(wake_eff)) |-> (hs_en == '0 && ls_en == '0 && !stat_n));

    // R6
    trip_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HB_TRIPPED) |-> (hs_en == '0 && ls_en == '0 && !stat_n && !sleep_o));
endmodule

// File: tb/hbridge_ctrl_tb_top.sv
module hbridge_ctrl_tb_top;
    logic       clk = 1'b0;
    logic       rst_n;
    logic [1:0] pol_in, pol_float;
    logic       dis_in, dis_float, wake_in, wake_float;
    logic       uv_flt, short_flt, hot_flt, temp_ok;
    logic [1:0] hs_en, ls_en;
    logic       stat_n, sleep_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    hbridge_ctrl #(.NUM_LEGS(2)) dut_i (
        .clk(clk), .rst_n(rst_n), .pol_in(pol_in), .pol_float(pol_float),
        .dis_in(dis_in), .dis_float(dis_float), .wake_in(wake_in),
        .wake_float(wake_float), .uv_flt(uv_flt), .short_flt(short_flt),
        .hot_flt(hot_flt), .temp_ok(temp_ok), .hs_en(hs_en), .ls_en(ls_en),
        .stat_n(stat_n), .sleep_o(sleep_o)
    );

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // Expected vector packed as {hs[1:0], ls[1:0], stat_n, sleep_o}.
    task automatic chk(input string tag, input logic [5:0] exp);
        logic [5:0] act;
        act = {hs_en, ls_en, stat_n, sleep_o};
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: act=%b exp=%b", tag, act, exp);
        end
    endtask

    function automatic logic [5:0] drv(input logic [1:0] p);
        return {p, ~p, 1'b1, 1'b0};
    endfunction

    localparam logic [5:0] OFF_LOW = 6'b0000_0_0;
    localparam logic [5:0] ASLEEP  = 6'b0000_1_1;

    task automatic t_reset();
        rst_n = 1'b0; pol_in = 2'b10; pol_float = 2'b00;
        dis_in = 1'b0; dis_float = 1'b0; wake_in = 1'b1; wake_float = 1'b0;
        uv_flt = 1'b0; short_flt = 1'b0; hot_flt = 1'b0; temp_ok = 1'b1;
        tick(); tick();
        chk("R1 in reset", ASLEEP);
        rst_n = 1'b1;
        #1 chk("R1 after release", ASLEEP);
        tick();
        chk("R1 first edge selects drive", drv(2'b10));
    endtask

    task automatic t_drive();
        for (int p = 0; p < 4; p++) begin
            pol_in = p[1:0];
            #1 chk("R2 polarity decode", drv(p[1:0]));
        end
    endtask

    task automatic t_disable();
        pol_in = 2'b01;
        dis_in = 1'b1; tick();
        chk("R3 disable off", OFF_LOW);
        pol_in = 2'b10; #1 chk("R11 both sides off when disabled", OFF_LOW);
        dis_in = 1'b0; tick();
        chk("R3 disable released", drv(2'b10));
    endtask

    task automatic t_sleep();
        wake_in = 1'b0; tick();
        chk("R4 sleep", ASLEEP);
        short_flt = 1'b1; hot_flt = 1'b1; tick();
        chk("R4 faults ignored asleep", ASLEEP);
        short_flt = 1'b0; hot_flt = 1'b0;
        wake_in = 1'b1; tick();
        chk("R4 wake", drv(2'b10));
    endtask

    task automatic t_uv();
        uv_flt = 1'b1; tick();
        chk("R5 uv off", OFF_LOW);
        uv_flt = 1'b0; tick();
        chk("R5 uv self recover", drv(2'b10));
    endtask

    task automatic t_short_dis_clear();
        short_flt = 1'b1; tick();
        chk("R6 short trips", OFF_LOW);
        short_flt = 1'b0; pol_in = 2'b11; tick();
        chk("R6 latch holds after fault gone", OFF_LOW);
        dis_in = 1'b1; tick();
        chk("R6 latch holds with disable high", OFF_LOW);
        dis_in = 1'b0; tick();
        chk("R7 disable fall clears", drv(2'b11));
    endtask

    task automatic t_wake_clear();
        short_flt = 1'b1; tick();
        short_flt = 1'b0; tick();
        chk("R6 short latched", OFF_LOW);
        wake_in = 1'b0; tick();
        chk("R12 latch overrides sleep", OFF_LOW);
        wake_in = 1'b1; tick();
        chk("R7 enable rise clears", drv(2'b11));
    endtask

    task automatic t_hot();
        hot_flt = 1'b1; tick();
        chk("R6 over-temp trips", OFF_LOW);
        hot_flt = 1'b0; temp_ok = 1'b0;
        dis_in = 1'b1; tick(); dis_in = 1'b0; tick();
        chk("R8 hot latch held while not cool", OFF_LOW);
        temp_ok = 1'b1;
        dis_in = 1'b1; tick(); dis_in = 1'b0; tick();
        chk("R8 hot latch released when cool", drv(2'b11));
    endtask

    task automatic t_relatch();
        pol_in = 2'b01;
        short_flt = 1'b1; tick();
        chk("R9 trip", OFF_LOW);
        dis_in = 1'b1; tick(); dis_in = 1'b0; tick();
        chk("R9 one released cycle", drv(2'b01));
        tick();
        chk("R9 re-latch", OFF_LOW);
        short_flt = 1'b0;
        dis_in = 1'b1; tick(); dis_in = 1'b0; tick();
        chk("R9 final clear", drv(2'b01));
    endtask

    task automatic t_float();
        pol_in = 2'b00; pol_float = 2'b10;
        #1 chk("R10 floating polarity reads 1", drv(2'b10));
        pol_float = 2'b11;
        #1 chk("R10 both floating", drv(2'b11));
        pol_float = 2'b00;
        dis_float = 1'b1; tick();
        chk("R10 floating disable", OFF_LOW);
        dis_float = 1'b0; tick();
        chk("R10 disable driven again", drv(2'b00));
        wake_float = 1'b1; tick();
        chk("R10 floating enable sleeps", ASLEEP);
        wake_float = 1'b0; tick();
        chk("R10 enable driven again", drv(2'b00));
    endtask

    task automatic t_priority();
        uv_flt = 1'b1; tick();
        short_flt = 1'b1; tick();
        short_flt = 1'b0; uv_flt = 1'b0; tick();
        chk("R12 fault during uv latches", OFF_LOW);
        dis_in = 1'b1; uv_flt = 1'b1; tick();
        dis_in = 1'b0; tick();
        chk("R12 release lands in uv", OFF_LOW);
        uv_flt = 1'b0; tick();
        chk("R12 uv recovers to drive", drv(2'b00));
    endtask

    initial begin
        t_reset();
        t_drive();
        t_disable();
        t_sleep();
        t_uv();
        t_short_dis_clear();
        t_wake_clear();
        t_hot();
        t_relatch();
        t_float();
        t_priority();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        #400000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: act=running exp=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule